// File: doc/BRIEF.md
# Event-Driven Sync Pulse Regenerator

This block rebuilds horizontal and vertical sync pulses for a pixel stream whose upstream link marks only the start of each sync period and sends no end marker. In event mode, a horizontal start event launches an HSYNC pulse. The pulse lasts a programmed number of pixel clocks. A vertical start event arms the vertical logic. The next horizontal start event then begins a VSYNC pulse, which lasts a programmed number of lines.

No porch is programmed. The front porch is whatever gap the source leaves between its last active pixel or line and the next start event. The back porch is what remains of the line or frame total. For example, a 2088-pixel line with 1920 active pixels, a 92-pixel front porch and a 14-pixel sync leaves a back porch of 62 pixels.

In pulse mode, the block follows upstream start and end markers directly. A data-enable output marks valid pixels that fall outside both sync pulses. All outputs are active high.

Top module: `sync_regen`

## Requirements
- R1: While reset is held (active-low `rstN`), and on the first cycle after it is released with no events present, `hSync`, `vSync` and `de` are 0.
- R2: In event mode (`pulseMode` = 0), a cycle with `hStartEv` = 1 and `hWidth` = W > 0 makes `hSync` 1 from the next cycle on, for exactly W consecutive pixel clocks.
- R3: In event mode, a horizontal start event with `hWidth` = 0 produces no HSYNC pulse.
- R4: In event mode, a horizontal start event that arrives while HSYNC is high restarts the count. HSYNC then stays high for W further cycles, counted from the restarting event.
- R5: `hWidth` is sampled only in the cycle of the horizontal start event. Changing it during a pulse does not change that pulse's length.
- R6: In event mode, a `vStartEv` arms the vertical logic. `vSync` rises on the cycle after the first later `hStartEv`; a horizontal event in the same cycle as `vStartEv` does not count. `vSync` falls on the cycle after the Vth further horizontal event, so it covers V lines.
- R7: `vWidth` is sampled in the cycle of `vStartEv`. A later change before the pulse does not affect it, and a sampled value of 0 produces no VSYNC pulse.
- R8: In pulse mode (`pulseMode` = 1), `hSync` becomes 1 on the cycle after `hStartEv` and 0 on the cycle after `hEndEv`. `vSync` does the same with `vStartEv` and `vEndEv`. The programmed widths have no effect.
- R9: `de` is 1 exactly when `pixValid` is 1 and both `hSync` and `vSync` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pulseMode | input | 1 | 0: sync widths come from programmed values; 1: upstream start/end markers |
| pixValid | input | 1 | Active pixel strobe |
| hStartEv | input | 1 | Horizontal sync-start event |
| hEndEv | input | 1 | Horizontal sync-end marker (pulse mode only) |
| vStartEv | input | 1 | Vertical sync-start event |
| vEndEv | input | 1 | Vertical sync-end marker (pulse mode only) |
| hWidth | input | H_WIDTH_BITS | HSYNC width in pixel clocks |
| vWidth | input | V_WIDTH_BITS | VSYNC width in lines |
| hSync | output | 1 | Regenerated horizontal sync |
| vSync | output | 1 | Regenerated vertical sync |
| de | output | 1 | Data enable |

## Verification
The bench measures HSYNC length to the exact cycle. An off-by-one counter would give W-1 or W+1 cycles. A restart inside a pulse is checked for a reload: a design that ignored the restart would stop early, and one that added to the count would run long. Width registers are changed in the middle of a pulse and between the vertical arm and its first line, which catches a design that reads the live register instead of the sampled value. The bench also checks that a horizontal event coinciding with the vertical start does not count as the first VSYNC line, that a zero width produces no pulse, and that pulse mode ignores the programmed widths.

// File: rtl/sync_regen_pkg.sv
package sync_regen_pkg;
  typedef struct packed {
    logic hLoad;     // reload horizontal width counter
    logic vCapture;  // sample vertical width
    logic vLoad;     // start vertical pulse from sampled width
    logic vDec;      // count one line of vertical pulse
  } syncStrobes_t;
endpackage

// File: rtl/sync_regen_ctrl.sv
module sync_regen_ctrl
  import sync_regen_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         pulseMode,
  input  logic         hStartEv,
  input  logic         vStartEv,
  output syncStrobes_t strobes
);
  logic armed;
  logic evMode;

  assign evMode = !pulseMode;

  always_comb begin
    strobes.hLoad    = evMode && hStartEv;
    strobes.vCapture = evMode && vStartEv;
    strobes.vLoad    = evMode && hStartEv && armed;
    strobes.vDec     = evMode && hStartEv && !armed;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 armed <= 1'b0;
    else if (strobes.vCapture) armed <= 1'b1;
    else if (strobes.vLoad)    armed <= 1'b0;
  end
endmodule

// File: rtl/sync_regen_datapath.sv
module sync_regen_datapath
  import sync_regen_pkg::*;
#(
  parameter int H_WIDTH_BITS = 16,
  parameter int V_WIDTH_BITS = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  syncStrobes_t            strobes,
  input  logic                    hStartEv,
  input  logic                    hEndEv,
  input  logic                    vStartEv,
  input  logic                    vEndEv,
  input  logic [H_WIDTH_BITS-1:0] hWidth,
  input  logic [V_WIDTH_BITS-1:0] vWidth,
  output logic                    hCntActive,
  output logic                    vCntActive,
  output logic                    hLevel,
  output logic                    vLevel
);
  localparam logic [H_WIDTH_BITS-1:0] H_ONE = H_WIDTH_BITS'(1);
  localparam logic [V_WIDTH_BITS-1:0] V_ONE = V_WIDTH_BITS'(1);

  logic [H_WIDTH_BITS-1:0] hCnt;
  logic [V_WIDTH_BITS-1:0] vCnt;
  logic [V_WIDTH_BITS-1:0] vHold;

  assign hCntActive = (hCnt != '0);
  assign vCntActive = (vCnt != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             hCnt <= '0;
    else if (strobes.hLoad) hCnt <= hWidth;
    else if (hCntActive)   hCnt <= hCnt - H_ONE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 vHold <= '0;
    else if (strobes.vCapture) vHold <= vWidth;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          vCnt <= '0;
    else if (strobes.vLoad)             vCnt <= vHold;
    else if (strobes.vDec && vCntActive) vCnt <= vCnt - V_ONE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hLevel <= 1'b0;
      vLevel <= 1'b0;
    end else begin
      if (hStartEv)    hLevel <= 1'b1;
      else if (hEndEv) hLevel <= 1'b0;
      if (vStartEv)    vLevel <= 1'b1;
      else if (vEndEv) vLevel <= 1'b0;
    end
  end
endmodule

// File: rtl/sync_regen.sv
module sync_regen
  import sync_regen_pkg::*;
#(
  parameter int H_WIDTH_BITS = 16,
  parameter int V_WIDTH_BITS = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    pulseMode,
  input  logic                    pixValid,
  input  logic                    hStartEv,
  input  logic                    hEndEv,
  input  logic                    vStartEv,
  input  logic                    vEndEv,
  input  logic [H_WIDTH_BITS-1:0] hWidth,
  input  logic [V_WIDTH_BITS-1:0] vWidth,
  output logic                    hSync,
  output logic                    vSync,
  output logic                    de
);
  syncStrobes_t strobes;
  logic hCntActive, vCntActive, hLevel, vLevel;

  sync_regen_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .pulseMode(pulseMode),
    .hStartEv(hStartEv), .vStartEv(vStartEv), .strobes(strobes)
  );

  sync_regen_datapath #(
    .H_WIDTH_BITS(H_WIDTH_BITS), .V_WIDTH_BITS(V_WIDTH_BITS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .hStartEv(hStartEv), .hEndEv(hEndEv),
    .vStartEv(vStartEv), .vEndEv(vEndEv),
    .hWidth(hWidth), .vWidth(vWidth),
    .hCntActive(hCntActive), .vCntActive(vCntActive),
    .hLevel(hLevel), .vLevel(vLevel)
  );

  assign hSync = pulseMode ? hLevel : hCntActive;
  assign vSync = pulseMode ? vLevel : vCntActive;
  assign de    = pixValid && !hSync && !vSync;
endmodule

// File: rtl/sync_regen_checker.sv
module sync_regen_checker #(
  parameter int H_WIDTH_BITS = 16
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    pulseMode,
  input logic                    hStartEv,
  input logic                    hEndEv,
  input logic                    vStartEv,
  input logic                    vEndEv,
  input logic [H_WIDTH_BITS-1:0] hWidth,
  input logic                    hSync,
  input logic                    vSync
);
  // R2
  a_r2_hsync_follows_start: assert property (@(posedge clk) disable iff (!rstN)
    (!pulseMode && hStartEv && hWidth != '0) |=> (pulseMode || hSync));

  // R3
  a_r3_zero_width_silent: assert property (@(posedge clk) disable iff (!rstN)
    (!pulseMode && hStartEv && hWidth == '0) |=> (pulseMode || !hSync));

  // R6
  a_r6_vsync_rise_on_line: assert property (@(posedge clk) disable iff (!rstN)
    (!pulseMode && $past(!pulseMode) && $rose(vSync)) |-> $past(hStartEv));

  // R6
  a_r6_vsync_fall_on_line: assert property (@(posedge clk) disable iff (!rstN)
    (!pulseMode && $past(!pulseMode) && $fell(vSync)) |-> $past(hStartEv));

  // R8
  a_r8_marker_end_h: assert property (@(posedge clk) disable iff (!rstN)
    (pulseMode && hEndEv && !hStartEv) |=> (!pulseMode || !hSync));

  // R8
  a_r8_marker_start_v: assert property (@(posedge clk) disable iff (!rstN)
    (pulseMode && vStartEv) |=> (!pulseMode || vSync));

  // R8
  a_r8_marker_end_v: assert property (@(posedge clk) disable iff (!rstN)
    (pulseMode && vEndEv && !vStartEv) |=> (!pulseMode || !vSync));
endmodule

bind sync_regen sync_regen_checker #(.H_WIDTH_BITS(H_WIDTH_BITS)) u_chk (
  .clk(clk), .rstN(rstN), .pulseMode(pulseMode),
  .hStartEv(hStartEv), .hEndEv(hEndEv),
  .vStartEv(vStartEv), .vEndEv(vEndEv),
  .hWidth(hWidth), .hSync(hSync), .vSync(vSync)
);

// File: tb/sync_regen_tb.sv
`timescale 1ns/1ps
module sync_regen_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pulseMode = 1'b0, pixValid = 1'b0;
  logic hStartEv = 1'b0, hEndEv = 1'b0, vStartEv = 1'b0, vEndEv = 1'b0;
  logic [15:0] hWidth = '0, vWidth = '0;
  logic hSync, vSync, de;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  sync_regen u_dut (
    .clk(clk), .rstN(rstN), .pulseMode(pulseMode), .pixValid(pixValid),
    .hStartEv(hStartEv), .hEndEv(hEndEv), .vStartEv(vStartEv), .vEndEv(vEndEv),
    .hWidth(hWidth), .vWidth(vWidth), .hSync(hSync), .vSync(vSync), .de(de)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  // One-cycle horizontal event, leaves the clock just after the sampling edge
  task automatic hPulse();
    hStartEv = 1'b1; step(); hStartEv = 1'b0;
  endtask

  task automatic measureH(output int len);
    len = 0;
    while (hSync && len < 200) begin len++; step(); end
  endtask

  task automatic test_reset();
    step(); step();
    check("R1 hSync in reset", hSync, 0);
    check("R1 vSync in reset", vSync, 0);
    check("R1 de in reset", de, 0);
    rstN = 1'b1; step();
    check("R1 hSync after reset", hSync, 0);
    check("R1 vSync after reset", vSync, 0);
  endtask

  task automatic test_hwidth();
    int len;
    hWidth = 16'd5; hPulse(); measureH(len);
    check("R2 width 5", len, 5);
    hWidth = 16'd1; hPulse(); measureH(len);
    check("R2 width 1", len, 1);
    hWidth = 16'd0; hPulse();
    check("R3 zero width", hSync, 0);
    step(); check("R3 zero width later", hSync, 0);
  endtask

  task automatic test_restart();
    int len;
    hWidth = 16'd4; hPulse();
    step();             // second high cycle
    hStartEv = 1'b1; step(); hStartEv = 1'b0;
    measureH(len);
    check("R4 restart adds full width", len + 2, 6);
  endtask

  task automatic test_midchange();
    int len;
    hWidth = 16'd6; hPulse();
    step(); hWidth = 16'd2;
    measureH(len);
    check("R5 mid-pulse update", len + 1, 6);
    hWidth = 16'd3;
  endtask

  task automatic lineEv(); // horizontal event then a few idle cycles
    hPulse(); step(); step(); step(); step();
  endtask

  task automatic test_vsync();
    hWidth = 16'd2; vWidth = 16'd3;
    vStartEv = 1'b1; step(); vStartEv = 1'b0;
    check("R6 no vSync on arm alone", vSync, 0);
    hPulse(); check("R6 vSync line1", vSync, 1);
    step(); step(); step(); step();
    hPulse(); check("R6 vSync line2", vSync, 1);
    step(); step(); step(); step();
    hPulse(); check("R6 vSync line3", vSync, 1);
    step(); step(); step(); step();
    hPulse(); check("R6 vSync ends after 3 lines", vSync, 0);
    step(); step(); step(); step();
    // coincident vertical and horizontal events
    vWidth = 16'd1;
    vStartEv = 1'b1; hStartEv = 1'b1; step(); vStartEv = 1'b0; hStartEv = 1'b0;
    check("R6 coincident line not counted", vSync, 0);
    step(); step(); step(); step();
    hPulse(); check("R6 vSync after next line", vSync, 1);
    step(); step(); step(); step();
    hPulse(); check("R6 width 1 ends", vSync, 0);
    step(); step(); step(); step();
  endtask

  task automatic test_vsample();
    int lines;
    vWidth = 16'd2;
    vStartEv = 1'b1; step(); vStartEv = 1'b0;
    vWidth = 16'd5;
    lines = 0;
    for (int i = 0; i < 8; i++) begin
      hPulse();
      if (vSync) lines++;
      step(); step(); step(); step();
    end
    check("R7 vWidth sampled at arm", lines, 2);
    vWidth = 16'd0;
    vStartEv = 1'b1; step(); vStartEv = 1'b0;
    lines = 0;
    for (int i = 0; i < 3; i++) begin
      hPulse();
      if (vSync) lines++;
      step(); step();
    end
    check("R7 zero vWidth", lines, 0);
  endtask

  task automatic test_pulse_mode();
    pulseMode = 1'b1; hWidth = 16'd3; vWidth = 16'd1;
    step();
    hPulse(); check("R8 hSync on start marker", hSync, 1);
    for (int i = 0; i < 10; i++) step();
    check("R8 width ignored", hSync, 1);
    hEndEv = 1'b1; step(); hEndEv = 1'b0;
    check("R8 hSync off at end marker", hSync, 0);
    vStartEv = 1'b1; step(); vStartEv = 1'b0;
    check("R8 vSync on start marker", vSync, 1);
    lineEv(); lineEv(); lineEv();
    check("R8 vSync held across lines", vSync, 1);
    vEndEv = 1'b1; step(); vEndEv = 1'b0;
    check("R8 vSync off at end marker", vSync, 0);
    hEndEv = 1'b1; step(); hEndEv = 1'b0;
    pulseMode = 1'b0; step(); step(); step(); step();
  endtask

  task automatic test_de();
    hWidth = 16'd3;
    pixValid = 1'b1; #1;
    check("R9 de with valid and no sync", de, 1);
    hPulse(); #1;
    check("R9 de blanked during hSync", de, 0);
    step(); step(); step(); #1;
    check("R9 de back after hSync", de, 1);
    pixValid = 1'b0; #1;
    check("R9 de low without valid", de, 0);
  endtask

  initial begin
    test_reset();
    test_hwidth();
    test_restart();
    test_midchange();
    test_vsync();
    test_vsample();
    test_pulse_mode();
    test_de();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule